// File: doc/BRIEF.md
# Subscriber Line Interface Controller

This block is the digital side of a ringing line interface chip. It drives that chip's control pins: a two-bit operating-mode code, an active-low power-down pin, a reset-select pin held high, and a cadenced low-level ringing logic signal. It also reads back the chip's two active-low detector outputs, switch-hook and ring-trip, through synchronizers and debounce counters. From the ringing phase and the detector wiring option it decides which detector is valid. A host issues commands to idle the line in normal feed, to start ringing, or to deny loop power. The host receives an off-hook level and a one-cycle ring-trip pulse.

The controller also protects against overheating. When the chip's active-low thermal alarm asserts, the controller forces power-down at once. It restores normal feed only after the alarm has stayed clear for a programmable cool-down interval. After reset, the line sits in the power-down-latch-reset mode for a fixed startup count and then enters normal feed. Ring on-time, ring off-time, debounce length, startup length and cool-down length are all counts of clock ticks.

Top module: `slic_line_ctrl`

## Requirements
- R1: While reset is asserted, and for STARTUP_TICKS rising edges after its release, `mode_code` is 01, `pwr_dn_n` is 0 and `ring_drive` is 0. On the next edge the block enters normal feed: `mode_code` 11 and `pwr_dn_n` 1.
- R2: A command is a one-cycle `cmd_valid` pulse with `cmd_code`. Code 00 selects normal feed, code 01 starts ringing and code 10 selects power denial (`mode_code` 00). Code 11 has no effect. All commands are ignored during startup and cool-down.
- R3: While ringing, `mode_code[1]` is 1 and `mode_code[0]` is the inverse of `single_det`: 11 with dual-detector wiring, 10 with single-detector wiring.
- R4: Each ringing burst begins with `ring_drive` high for RING_ON_TICKS cycles. It is then low for RING_OFF_TICKS cycles, and the pattern repeats while ringing continues.
- R5: `ring_drive` is 0 whenever the block is not ringing, including in power-down.
- R6: While ringing with `single_det` 0, only `det_rtd_n` indicates off-hook. In every other case only `det_shd_n` does.
- R7: In power denial both detectors are ignored and `offhook` stays 0.
- R8: When a valid off-hook becomes effective during ringing, `ring_drive` is 0 in that same cycle. In the next cycle the block is in normal feed (`mode_code` 11) with `ring_trip` high for exactly one cycle.
- R9: Detector inputs pass through two synchronizing flops and must then hold a new level for DEBOUNCE_TICKS cycles. A low level at a detector pin raises `offhook` DEBOUNCE_TICKS+2 edges later, and a shorter pulse is ignored.
- R10: Within three rising edges of `therm_alm_n` going low, `pwr_dn_n` is 0, `mode_code` is 01 and `ring_drive` is 0, from any state.
- R11: In cool-down, normal feed returns only once the synchronized alarm has been clear for COOL_TICKS consecutive cycles. Any recurrence of the alarm restarts the count.
- R12: `rst_sel` is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_code | input | 2 | 00 feed, 01 ring, 10 deny, 11 reserved |
| single_det | input | 1 | 1 = single-detector wiring, 0 = dual |
| det_shd_n | input | 1 | Switch-hook detector, active low |
| det_rtd_n | input | 1 | Ring-trip detector, active low |
| therm_alm_n | input | 1 | Thermal alarm, active low |
| mode_code | output | 2 | Mode pins {F1,F0} to the line chip |
| pwr_dn_n | output | 1 | Power-down (test) pin, active low |
| rst_sel | output | 1 | Reset-select pin, held high |
| ring_drive | output | 1 | Cadenced ringing logic signal |
| offhook | output | 1 | Valid off-hook to host |
| ring_trip | output | 1 | One-cycle pulse on ring trip |

## Verification
The bench builds the block with a startup of 8 ticks, 6 on and 10 off for the cadence, a debounce of 3 and a cool-down of 12. With these values a full on/off/on cadence cycle, an exact debounce latency and a complete cool-down with a restart all fit into a few hundred cycles. The short on-time lets the bench assert ring-trip inside the first on-phase, so the same-cycle forcing of the ringing signal to low is visible. The restart case re-pulses the alarm partway through cool-down and checks that power-down still holds a full interval later.

// File: rtl/slic_line_ctrl.sv
module slic_line_ctrl #(
  parameter int unsigned STARTUP_TICKS  = 1000,
  parameter int unsigned RING_ON_TICKS  = 2_000_000,
  parameter int unsigned RING_OFF_TICKS = 4_000_000,
  parameter int unsigned DEBOUNCE_TICKS = 5000,
  parameter int unsigned COOL_TICKS     = 10_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_code,
  input  logic       single_det,
  input  logic       det_shd_n,
  input  logic       det_rtd_n,
  input  logic       therm_alm_n,
  output logic [1:0] mode_code,
  output logic       pwr_dn_n,
  output logic       rst_sel,
  output logic       ring_drive,
  output logic       offhook,
  output logic       ring_trip
);

  localparam int unsigned T_A  = (STARTUP_TICKS > RING_ON_TICKS) ? STARTUP_TICKS : RING_ON_TICKS;
  localparam int unsigned T_B  = (RING_OFF_TICKS > COOL_TICKS) ? RING_OFF_TICKS : COOL_TICKS;
  localparam int unsigned TMAX = (T_A > T_B) ? T_A : T_B;
  localparam int unsigned CW   = $clog2(TMAX + 1);
  localparam int unsigned DW   = $clog2(DEBOUNCE_TICKS + 1);

  typedef enum logic [2:0] {S_BOOT, S_FEED, S_RING, S_DENY, S_COOL} state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic          ph_on;
  logic [1:0]    sy1, sy2, deb;
  logic [DW-1:0] dcnt [2];
  logic          alm1, alm2;
  logic          alarm, sel_rtd, valid_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1  <= 2'b11;
      sy2  <= 2'b11;
      alm1 <= 1'b1;
      alm2 <= 1'b1;
    end else begin
      sy1  <= {det_rtd_n, det_shd_n};
      sy2  <= sy1;
      alm1 <= therm_alm_n;
      alm2 <= alm1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deb <= 2'b11;
      for (int i = 0; i < 2; i++) dcnt[i] <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (sy2[i] != deb[i]) begin
          if (dcnt[i] == DW'(DEBOUNCE_TICKS - 1)) begin
            deb[i]  <= sy2[i];
            dcnt[i] <= '0;
          end else begin
            dcnt[i] <= dcnt[i] + 1'b1;
          end
        end else begin
          dcnt[i] <= '0;
        end
      end
    end
  end

  assign alarm     = !alm2;
  assign sel_rtd   = (st == S_RING) && !single_det;
  assign valid_off = sel_rtd ? !deb[1] : !deb[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_BOOT;
      cnt       <= '0;
      ph_on     <= 1'b0;
      ring_trip <= 1'b0;
    end else begin
      ring_trip <= 1'b0;
      if (alarm && st != S_COOL) begin
        st    <= S_COOL;
        cnt   <= '0;
        ph_on <= 1'b0;
      end else begin
        case (st)
          S_BOOT: begin
            if (cnt == CW'(STARTUP_TICKS - 1)) begin
              st  <= S_FEED;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_FEED, S_DENY: begin
            if (cmd_valid) begin
              case (cmd_code)
                2'b00: st <= S_FEED;
                2'b01: begin
                  st    <= S_RING;
                  ph_on <= 1'b1;
                  cnt   <= '0;
                end
                2'b10: st <= S_DENY;
                default: ;
              endcase
            end
          end
          S_RING: begin
            if (valid_off) begin
              st        <= S_FEED;
              ring_trip <= 1'b1;
              ph_on     <= 1'b0;
              cnt       <= '0;
            end else if (cmd_valid && (cmd_code == 2'b00 || cmd_code == 2'b10)) begin
              st    <= (cmd_code == 2'b00) ? S_FEED : S_DENY;
              ph_on <= 1'b0;
              cnt   <= '0;
            end else if (ph_on && cnt == CW'(RING_ON_TICKS - 1)) begin
              ph_on <= 1'b0;
              cnt   <= '0;
            end else if (!ph_on && cnt == CW'(RING_OFF_TICKS - 1)) begin
              ph_on <= 1'b1;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_COOL: begin
            if (alarm) begin
              cnt <= '0;
            end else if (cnt == CW'(COOL_TICKS - 1)) begin
              st  <= S_FEED;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= S_BOOT;
        endcase
      end
    end
  end

  always_comb begin
    case (st)
      S_FEED:  begin mode_code = 2'b11;              pwr_dn_n = 1'b1; end
      S_RING:  begin mode_code = {1'b1, !single_det}; pwr_dn_n = 1'b1; end
      S_DENY:  begin mode_code = 2'b00;              pwr_dn_n = 1'b1; end
      default: begin mode_code = 2'b01;              pwr_dn_n = 1'b0; end
    endcase
  end

  assign rst_sel    = 1'b1;
  assign ring_drive = (st == S_RING) && ph_on && !valid_off;
  assign offhook    = valid_off && (st == S_FEED || st == S_RING);

  assert_pd_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_dn_n |-> !ring_drive);

  assert_ring_f1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ring_drive |-> (mode_code[1] && mode_code[0] == !single_det));

  assert_deny_blind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'b00) |-> !offhook);

  assert_alarm_pd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !alm2 |=> !pwr_dn_n);

  assert_trip_feed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ring_trip |-> (mode_code == 2'b11 && !ring_drive));

  assert_trip_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ring_trip |=> !ring_trip);

endmodule

// File: tb/tb_slic_line_ctrl.sv
module tb_slic_line_ctrl;
  localparam int STU = 8, RON = 6, ROFF = 10, DEB = 3, COOL = 12;

  logic clk = 0, rst_n = 0, cmd_valid = 0, single_det = 0;
  logic [1:0] cmd_code = 2'b00;
  logic det_shd_n = 1, det_rtd_n = 1, therm_alm_n = 1;
  logic [1:0] mode_code;
  logic pwr_dn_n, rst_sel, ring_drive, offhook, ring_trip;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  slic_line_ctrl #(.STARTUP_TICKS(STU), .RING_ON_TICKS(RON), .RING_OFF_TICKS(ROFF),
                   .DEBOUNCE_TICKS(DEB), .COOL_TICKS(COOL)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .single_det(single_det), .det_shd_n(det_shd_n), .det_rtd_n(det_rtd_n),
    .therm_alm_n(therm_alm_n), .mode_code(mode_code), .pwr_dn_n(pwr_dn_n),
    .rst_sel(rst_sel), .ring_drive(ring_drive), .offhook(offhook), .ring_trip(ring_trip));

  // {cmd_code, single_det, expected mode_code, expected ring_drive}
  localparam logic [5:0] VEC [8] = '{
    {2'b10, 1'b0, 2'b00, 1'b0},
    {2'b11, 1'b0, 2'b00, 1'b0},
    {2'b01, 1'b0, 2'b11, 1'b1},
    {2'b00, 1'b0, 2'b11, 1'b0},
    {2'b01, 1'b1, 2'b10, 1'b1},
    {2'b10, 1'b1, 2'b00, 1'b0},
    {2'b00, 1'b1, 2'b11, 1'b0},
    {2'b11, 1'b1, 2'b11, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] c);
    @(negedge clk);
    cmd_valid = 1; cmd_code = c;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seen;
    int n;
    waitn(3);
    chk("R1 reset mode", mode_code, 1);
    chk("R1 reset pwr_dn_n", pwr_dn_n, 0);
    chk("R1 reset ring", ring_drive, 0);
    chk("R12 rst_sel", rst_sel, 1);
    rst_n = 1;
    repeat (STU - 1) @(posedge clk);
    @(negedge clk);
    chk("R1 still boot", mode_code, 1);
    cmd_valid = 1; cmd_code = 2'b10;
    @(negedge clk);
    cmd_valid = 0;
    chk("R1 feed mode R2 boot cmd ignored", mode_code, 3);
    chk("R1 feed pwr", pwr_dn_n, 1);

    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      single_det = VEC[k][3];
      cmd_valid = 1; cmd_code = VEC[k][5:4];
      @(negedge clk);
      cmd_valid = 0;
      chk("R2 R3 vector mode", mode_code, VEC[k][2:1]);
      chk("R5 R4 vector ring", ring_drive, VEC[k][0]);
    end

    // R4 cadence
    single_det = 0;
    cmd(2'b01);
    n = 0;
    for (int i = 0; i < RON + ROFF + 2; i++) begin
      if (ring_drive != ((i < RON) || (i >= RON + ROFF))) n++;
      @(negedge clk);
    end
    chk("R4 cadence mismatches", n, 0);
    cmd(2'b00);
    chk("R5 ring low in feed", ring_drive, 0);

    // R7 deny ignores detectors
    cmd(2'b10);
    det_shd_n = 0; det_rtd_n = 0;
    waitn(DEB + 6);
    chk("R7 deny offhook", offhook, 0);
    chk("R7 deny mode", mode_code, 0);
    cmd(2'b00);
    chk("R6 feed uses switch-hook", offhook, 1);
    det_shd_n = 1; det_rtd_n = 1;
    waitn(DEB + 6);
    chk("R6 on-hook again", offhook, 0);

    // R9 glitch and latency
    @(negedge clk) det_shd_n = 0;
    @(negedge clk) det_shd_n = 1;
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      if (offhook) seen = 1;
      @(negedge clk);
    end
    chk("R9 glitch ignored", seen, 0);
    det_shd_n = 0;
    repeat (DEB + 1) @(posedge clk);
    @(negedge clk);
    chk("R9 not yet", offhook, 0);
    @(negedge clk);
    chk("R9 latency", offhook, 1);
    det_shd_n = 1;
    waitn(DEB + 6);

    // R6 dual: switch-hook ignored while ringing
    single_det = 0;
    det_shd_n = 0;
    waitn(DEB + 6);
    cmd(2'b01);
    seen = 0;
    for (int i = 0; i < DEB + 6; i++) begin
      if (offhook || ring_trip) seen = 1;
      @(negedge clk);
    end
    chk("R6 dual ignores switch-hook", seen, 0);
    cmd(2'b00);
    det_shd_n = 1;
    waitn(DEB + 6);

    // R8 dual ring trip in first on phase
    @(negedge clk);
    cmd_valid = 1; cmd_code = 2'b01; det_rtd_n = 0;
    @(negedge clk);
    cmd_valid = 0;
    n = 0;
    while (!offhook && n < 20) begin @(negedge clk); n++; end
    chk("R8 offhook seen", offhook, 1);
    chk("R8 ring forced low", ring_drive, 0);
    chk("R8 trip not yet", ring_trip, 0);
    @(negedge clk);
    chk("R8 trip pulse", ring_trip, 1);
    chk("R8 feed after trip", mode_code, 3);
    @(negedge clk);
    chk("R8 trip one cycle", ring_trip, 0);
    det_rtd_n = 1;
    waitn(DEB + 6);

    // R6 single: ring-trip pin ignored, switch-hook used
    single_det = 1;
    cmd(2'b01);
    det_rtd_n = 0;
    seen = 0;
    for (int i = 0; i < DEB + 6; i++) begin
      if (offhook || ring_trip) seen = 1;
      @(negedge clk);
    end
    chk("R6 single ignores ring-trip pin", seen, 0);
    chk("R3 single ring mode", mode_code, 2);
    det_shd_n = 0;
    n = 0; seen = 0;
    while (n < 20) begin
      if (ring_trip) seen = 1;
      @(negedge clk); n++;
    end
    chk("R6 single trip via switch-hook", seen, 1);
    chk("R8 single back to feed", mode_code, 3);
    det_shd_n = 1; det_rtd_n = 1; single_det = 0;
    waitn(DEB + 6);

    // R10 alarm during ringing
    cmd(2'b01);
    @(negedge clk) therm_alm_n = 0;
    waitn(3);
    chk("R10 pwr down", pwr_dn_n, 0);
    chk("R10 mode", mode_code, 1);
    chk("R10 ring low", ring_drive, 0);
    cmd(2'b01);
    chk("R2 cmd ignored in cool-down", mode_code, 1);
    waitn(20);
    therm_alm_n = 1;
    waitn(6);
    therm_alm_n = 0;
    waitn(2);
    therm_alm_n = 1;
    waitn(COOL);
    chk("R11 restart holds power-down", pwr_dn_n, 0);
    waitn(6);
    chk("R11 recovered pwr", pwr_dn_n, 1);
    chk("R11 recovered mode", mode_code, 3);
    chk("R12 rst_sel end", rst_sel, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule